// File: doc/BRIEF.md
# Power-Sourcing Port Detection Sequencer

This block is the top-level controller of one power-sourcing port. It waits until the port is enabled and ready and until neither pairset has power on it. It then raises a detection-start strobe and evaluates the results that the measurement logic returns: primary detection done, secondary detection done, connection check done, a timer-fault flag, the two signature-valid flags and the signature type. From that evaluation it goes to one of four places: a timed backoff, ordinary classification, the dual-signature independent-handling start, or back to idle.

An enable input overrides everything else. While the port is enabled, a reset request, a classification current-limit event or an error condition sends the controller back to idle. Backoff time is counted in pulses of a tick-enable input, so the caller sets the time base. All control and status pins are plain levels. The block has no data stream and no handshake.

Top module: `pse_detect_seq`

## Requirements
- R1: A synchronous `rst` puts the controller in idle: `state_code` = 0 and `det_start` and `indep_mode` low. Code map: 0 idle, 1 detect-start, 2 evaluate, 3 backoff, 4 classify, 5 independent-start, 6 disabled.
- R2: Idle moves to detect-start (code 1) only when `ready` and `en` are high and `pwr_pri` and `pwr_sec` are both low. Otherwise it stays in idle.
- R3: `det_start` is high for exactly the one cycle spent in detect-start. The controller then always enters evaluate (code 2) with `det_start` low.
- R4: Evaluate holds until `timer_fault` is set, or until `pri_done` is set and either `alt_sel` is not both (`alt_sel` 0 = A, 1 = B, 2 = both) or `sec_done` and `cxn_done` are both set.
- R5: An evaluate exit with `timer_fault` set returns to idle, whatever the signatures are.
- R6: With no fault, B alternative and `sig_pri_ok` low, evaluate goes to backoff (code 3). Backoff lasts exactly BACKOFF_TICKS cycles in which `tick_en` is high, then returns to idle. Cycles with `tick_en` low do not advance it.
- R7: With no fault, alternative both, both signatures valid and `sig_kind` = dual (`sig_kind` 0 = invalid, 1 = single, 2 = dual), evaluate goes to independent-start (code 5) with `indep_mode` high. The controller holds there.
- R8: With no fault and `sig_pri_ok` high, evaluate goes to classify (code 4) when the alternative is not both. With alternative both, it also needs `sig_sec_ok` high and `sig_kind` = single. The controller holds there.
- R9: Every other evaluate exit (an invalid primary on A, or an invalid secondary or mismatched type on both) returns to idle.
- R10: `en` low forces disabled (code 6) from any state, with `det_start` and `indep_mode` low. Disabled returns to idle in the cycle after `en` is high again.
- R11: While `en` is high, `reset_req`, `cls_limit` or `err_cond` forces idle from any state. A disable in the same cycle wins.

Top module ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_en | input | 1 | Time-base pulse for the backoff timer |
| en | input | 1 | Port enable; low means disabled |
| reset_req | input | 1 | Request to restart from idle |
| cls_limit | input | 1 | Classification current-limit event |
| err_cond | input | 1 | Error condition |
| ready | input | 1 | Port ready to start detection |
| pwr_pri | input | 1 | Power applied on primary pairset |
| pwr_sec | input | 1 | Power applied on secondary pairset |
| alt_sel | input | 2 | Pinout alternative: 0 A, 1 B, 2 both |
| pri_done | input | 1 | Primary detection finished |
| sec_done | input | 1 | Secondary detection finished |
| cxn_done | input | 1 | Connection check finished |
| timer_fault | input | 1 | Detection timer fault |
| sig_pri_ok | input | 1 | Primary signature valid |
| sig_sec_ok | input | 1 | Secondary signature valid |
| sig_kind | input | 2 | Signature type: 0 invalid, 1 single, 2 dual |
| det_start | output | 1 | Detection-start strobe |
| indep_mode | output | 1 | Independent dual-signature mode flag |
| state_code | output | 3 | Current state code |

## Verification
Several pairs of events can fall in the same cycle. A disable can arrive together with a reset request while the controller is in evaluate, and a disable can arrive on the very tick that ends backoff; in both cases the bench expects disabled, not idle. A timer fault can also arrive together with completed detection and valid signatures; the bench expects idle, not classify. Each collision is set up by driving both inputs in the same cycle, and the state code one edge later is compared against the value predicted from the priority order.

// File: rtl/pse_seq_pkg.sv
package pse_seq_pkg;
  typedef enum logic [2:0] {
    S_IDLE     = 3'd0,
    S_DSTART   = 3'd1,
    S_EVAL     = 3'd2,
    S_BACKOFF  = 3'd3,
    S_CLASSIFY = 3'd4,
    S_INDEP    = 3'd5,
    S_DISABLED = 3'd6
  } seq_state_t;

  localparam logic [1:0] ALT_A    = 2'd0;
  localparam logic [1:0] ALT_B    = 2'd1;
  localparam logic [1:0] ALT_BOTH = 2'd2;

  localparam logic [1:0] KIND_INVALID = 2'd0;
  localparam logic [1:0] KIND_SINGLE  = 2'd1;
  localparam logic [1:0] KIND_DUAL    = 2'd2;
endpackage

// File: rtl/pse_seq_backoff.sv
module pse_seq_backoff #(
  parameter int TICKS = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic tick,
  output logic expired
);
  localparam int CW = (TICKS > 1) ? $clog2(TICKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

  logic [CW-1:0] cnt;

  assign expired = run && tick && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (tick)   cnt <= expired ? '0 : cnt + 1'b1;
  end

  // R6: the tick count never passes the programmed length
  assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST);
  // R6: without a tick the count holds
  assert_hold_no_tick_R6: assert property (@(posedge clk) disable iff (rst)
    (run && !tick) |=> (!run || $stable(cnt)));
endmodule

// File: rtl/pse_seq_route.sv
module pse_seq_route
  import pse_seq_pkg::*;
(
  input  logic [1:0]  alt_sel,
  input  logic        pri_done,
  input  logic        sec_done,
  input  logic        cxn_done,
  input  logic        timer_fault,
  input  logic        sig_pri_ok,
  input  logic        sig_sec_ok,
  input  logic [1:0]  sig_kind,
  output logic        exit_ok,
  output seq_state_t  dest
);
  logic both_alt;
  assign both_alt = (alt_sel == ALT_BOTH);

  always_comb begin
    exit_ok = timer_fault || (pri_done && (!both_alt || (sec_done && cxn_done)));
    if (timer_fault)
      dest = S_IDLE;
    else if (pri_done && alt_sel == ALT_B && !sig_pri_ok)
      dest = S_BACKOFF;
    else if (both_alt && sig_pri_ok && sig_sec_ok && sig_kind == KIND_DUAL)
      dest = S_INDEP;
    else if (sig_pri_ok && (!both_alt || (sig_sec_ok && sig_kind == KIND_SINGLE)))
      dest = S_CLASSIFY;
    else
      dest = S_IDLE;
  end

  // R5: a fault always routes to idle
  assert_fault_route_R5: assert final (!timer_fault || dest == S_IDLE);
endmodule

// File: rtl/pse_detect_seq.sv
module pse_detect_seq
  import pse_seq_pkg::*;
#(
  parameter int BACKOFF_TICKS = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick_en,
  input  logic       en,
  input  logic       reset_req,
  input  logic       cls_limit,
  input  logic       err_cond,
  input  logic       ready,
  input  logic       pwr_pri,
  input  logic       pwr_sec,
  input  logic [1:0] alt_sel,
  input  logic       pri_done,
  input  logic       sec_done,
  input  logic       cxn_done,
  input  logic       timer_fault,
  input  logic       sig_pri_ok,
  input  logic       sig_sec_ok,
  input  logic [1:0] sig_kind,
  output logic       det_start,
  output logic       indep_mode,
  output logic [2:0] state_code
);
  seq_state_t st, st_nx, route_dest;
  logic       route_exit, bo_expired, restart, start_ok;
  logic       det_q, indep_q;

  pse_seq_route u_route (
    .alt_sel(alt_sel), .pri_done(pri_done), .sec_done(sec_done),
    .cxn_done(cxn_done), .timer_fault(timer_fault),
    .sig_pri_ok(sig_pri_ok), .sig_sec_ok(sig_sec_ok), .sig_kind(sig_kind),
    .exit_ok(route_exit), .dest(route_dest)
  );

  pse_seq_backoff #(.TICKS(BACKOFF_TICKS)) u_backoff (
    .clk(clk), .rst(rst), .run(st == S_BACKOFF), .tick(tick_en),
    .expired(bo_expired)
  );

  assign restart  = reset_req || cls_limit || err_cond;
  assign start_ok = ready && en && !pwr_pri && !pwr_sec;

  always_comb begin
    st_nx = st;
    if (!en)
      st_nx = S_DISABLED;
    else if (restart)
      st_nx = S_IDLE;
    else begin
      unique case (st)
        S_IDLE:     if (start_ok) st_nx = S_DSTART;
        S_DSTART:   st_nx = S_EVAL;
        S_EVAL:     if (route_exit) st_nx = route_dest;
        S_BACKOFF:  if (bo_expired) st_nx = S_IDLE;
        S_DISABLED: st_nx = S_IDLE;
        default:    st_nx = st;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= S_IDLE;
      det_q   <= 1'b0;
      indep_q <= 1'b0;
    end else begin
      st      <= st_nx;
      det_q   <= (st_nx == S_DSTART);
      if (st_nx == S_INDEP)
        indep_q <= 1'b1;
      else if (st_nx == S_IDLE || st_nx == S_DISABLED)
        indep_q <= 1'b0;
    end
  end

  assign det_start  = det_q;
  assign indep_mode = indep_q;
  assign state_code = st;

  assert_disable_R10: assert property (@(posedge clk) disable iff (rst)
    !en |=> (state_code == 3'd6 && !det_start && !indep_mode));
  assert_restart_idle_R11: assert property (@(posedge clk) disable iff (rst)
    (en && restart) |=> state_code == 3'd0);
  assert_gate_start_R2: assert property (@(posedge clk) disable iff (rst)
    (st == S_IDLE && !start_ok) |=> st != S_DSTART);
  assert_strobe_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    det_start |=> !det_start);
  assert_eval_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (st == S_EVAL && en && !restart && !timer_fault && !pri_done) |=> st == S_EVAL);
  assert_indep_flag_R7: assert property (@(posedge clk) disable iff (rst)
    indep_mode |-> st == S_INDEP);
endmodule

// File: tb/pse_detect_seq_tb.sv
module pse_detect_seq_tb;
  localparam int BT = 3;
  localparam logic [2:0] C_IDLE = 3'd0, C_DS = 3'd1, C_EV = 3'd2, C_BO = 3'd3,
                         C_CL = 3'd4, C_IN = 3'd5, C_DIS = 3'd6;

  logic clk = 1'b0;
  logic rst, tick_en, en, reset_req, cls_limit, err_cond, ready, pwr_pri, pwr_sec;
  logic [1:0] alt_sel, sig_kind;
  logic pri_done, sec_done, cxn_done, timer_fault, sig_pri_ok, sig_sec_ok;
  logic det_start, indep_mode;
  logic [2:0] state_code;

  always #10 clk = ~clk;

  pse_detect_seq #(.BACKOFF_TICKS(BT)) u_dut (
    .clk(clk), .rst(rst), .tick_en(tick_en), .en(en), .reset_req(reset_req),
    .cls_limit(cls_limit), .err_cond(err_cond), .ready(ready),
    .pwr_pri(pwr_pri), .pwr_sec(pwr_sec), .alt_sel(alt_sel),
    .pri_done(pri_done), .sec_done(sec_done), .cxn_done(cxn_done),
    .timer_fault(timer_fault), .sig_pri_ok(sig_pri_ok), .sig_sec_ok(sig_sec_ok),
    .sig_kind(sig_kind), .det_start(det_start), .indep_mode(indep_mode),
    .state_code(state_code)
  );

  typedef struct { logic [2:0] st; logic ds; logic im; string tag; } exp_t;
  exp_t q[$];
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  // monitor: compare one expectation per falling edge
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      n_chk++;
      if (state_code !== e.st || det_start !== e.ds || indep_mode !== e.im) begin
        n_fail++;
        $display("FAIL %s: got st=%0d ds=%0b im=%0b, expected st=%0d ds=%0b im=%0b",
                 e.tag, state_code, det_start, indep_mode, e.st, e.ds, e.im);
      end
    end
  end

  // driver: one clock edge, then queue the expected outputs
  task automatic cyc(input logic [2:0] s, input logic d, input logic i, input string tag);
    exp_t e;
    @(posedge clk);
    e.st = s; e.ds = d; e.im = i; e.tag = tag;
    q.push_back(e);
    @(negedge clk);
  endtask

  task automatic clear_results();
    pri_done = 0; sec_done = 0; cxn_done = 0; timer_fault = 0;
    sig_pri_ok = 0; sig_sec_ok = 0; sig_kind = 2'd0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (3000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got hung run, expected completion");
      finish_run();
    end
  end

  initial begin
    rst = 1; tick_en = 0; en = 1; reset_req = 0; cls_limit = 0; err_cond = 0;
    ready = 0; pwr_pri = 0; pwr_sec = 0; alt_sel = 2'd0; clear_results();
    @(negedge clk);
    cyc(C_IDLE, 0, 0, "R1 reset");
    rst = 0;
    cyc(C_IDLE, 0, 0, "R1 idle after reset");

    // R2 gating
    pwr_pri = 1; ready = 1;
    cyc(C_IDLE, 0, 0, "R2 primary powered");
    pwr_pri = 0; pwr_sec = 1;
    cyc(C_IDLE, 0, 0, "R2 secondary powered");
    pwr_sec = 0;
    cyc(C_DS, 1, 0, "R2 start allowed");
    ready = 0;
    cyc(C_EV, 0, 0, "R3 strobe drops in eval");
    cyc(C_EV, 0, 0, "R4 hold without done");
    pri_done = 1; sig_pri_ok = 1;
    cyc(C_CL, 0, 0, "R8 classify on A");
    cyc(C_CL, 0, 0, "R8 classify holds");
    reset_req = 1;
    cyc(C_IDLE, 0, 0, "R11 reset request");
    reset_req = 0; clear_results();

    // both alternatives, dual signature
    alt_sel = 2'd2; ready = 1;
    cyc(C_DS, 1, 0, "R2 start both");
    ready = 0;
    cyc(C_EV, 0, 0, "R3 eval both");
    pri_done = 1;
    cyc(C_EV, 0, 0, "R4 both waits for secondary");
    sec_done = 1;
    cyc(C_EV, 0, 0, "R4 both waits for check");
    cxn_done = 1; sig_pri_ok = 1; sig_sec_ok = 1; sig_kind = 2'd2;
    cyc(C_IN, 0, 1, "R7 independent start");
    cyc(C_IN, 0, 1, "R7 independent holds");
    cls_limit = 1;
    cyc(C_IDLE, 0, 0, "R11 current limit");
    cls_limit = 0; clear_results();

    // both, single type
    ready = 1;
    cyc(C_DS, 1, 0, "R2 start single");
    ready = 0;
    cyc(C_EV, 0, 0, "R3 eval single");
    pri_done = 1; sec_done = 1; cxn_done = 1; sig_pri_ok = 1; sig_sec_ok = 1; sig_kind = 2'd1;
    cyc(C_CL, 0, 0, "R8 classify single on both");
    err_cond = 1;
    cyc(C_IDLE, 0, 0, "R11 error condition");
    err_cond = 0; clear_results();

    // both, secondary invalid with dual type -> idle
    ready = 1;
    cyc(C_DS, 1, 0, "R2 start mismatch");
    ready = 0;
    pri_done = 1; sec_done = 1; cxn_done = 1; sig_pri_ok = 1; sig_kind = 2'd2;
    cyc(C_EV, 0, 0, "R3 eval mismatch");
    cyc(C_IDLE, 0, 0, "R9 secondary invalid");
    clear_results();

    // fault collides with valid signatures
    alt_sel = 2'd0; ready = 1;
    cyc(C_DS, 1, 0, "R2 start fault");
    ready = 0;
    pri_done = 1; sig_pri_ok = 1; timer_fault = 1;
    cyc(C_EV, 0, 0, "R3 eval fault");
    cyc(C_IDLE, 0, 0, "R5 fault beats classify");
    clear_results();

    // invalid primary on A -> idle
    ready = 1;
    cyc(C_DS, 1, 0, "R2 start A invalid");
    ready = 0; pri_done = 1;
    cyc(C_EV, 0, 0, "R3 eval A invalid");
    cyc(C_IDLE, 0, 0, "R9 invalid primary on A");
    clear_results();

    // backoff on B
    alt_sel = 2'd1; ready = 1;
    cyc(C_DS, 1, 0, "R2 start B");
    ready = 0; pri_done = 1;
    cyc(C_EV, 0, 0, "R3 eval B");
    cyc(C_BO, 0, 0, "R6 enter backoff");
    clear_results();
    cyc(C_BO, 0, 0, "R6 no tick holds");
    cyc(C_BO, 0, 0, "R6 no tick holds again");
    tick_en = 1;
    for (int k = 1; k < BT; k++) cyc(C_BO, 0, 0, "R6 ticking");
    cyc(C_IDLE, 0, 0, "R6 backoff expiry");
    tick_en = 0;

    // disable collides with backoff expiry
    ready = 1;
    cyc(C_DS, 1, 0, "R2 start B again");
    ready = 0; pri_done = 1;
    cyc(C_EV, 0, 0, "R3 eval B again");
    cyc(C_BO, 0, 0, "R6 backoff again");
    clear_results(); tick_en = 1;
    for (int k = 1; k < BT; k++) cyc(C_BO, 0, 0, "R6 ticking again");
    en = 0;
    cyc(C_DIS, 0, 0, "R10 disable beats expiry");
    tick_en = 0;
    cyc(C_DIS, 0, 0, "R10 stays disabled");
    en = 1;
    cyc(C_IDLE, 0, 0, "R10 re-enable");

    // disable collides with reset request in eval
    alt_sel = 2'd0; ready = 1;
    cyc(C_DS, 1, 0, "R2 start collide");
    ready = 0;
    cyc(C_EV, 0, 0, "R3 eval collide");
    en = 0; reset_req = 1;
    cyc(C_DIS, 0, 0, "R11 disable beats reset request");
    reset_req = 0;
    // disable from detect-start
    en = 1; ready = 1;
    cyc(C_IDLE, 0, 0, "R10 back to idle");
    cyc(C_DS, 1, 0, "R2 start before disable");
    en = 0;
    cyc(C_DIS, 0, 0, "R10 disable clears strobe");
    en = 1; ready = 0;
    cyc(C_IDLE, 0, 0, "R10 idle again");

    @(negedge clk);
    finished = 1;
    finish_run();
  end
endmodule